// File: doc/BRIEF.md
# Power-Up Cipher Self-Test Sequencer

This block runs once after every reset and holds normal traffic back until a cipher engine has proven itself against a set of built-in known-answer vectors. It drives the engine's key, data and mode inputs and pulses its start input for one vector at a time. It then waits for the engine's done strobe and compares the returned word with the stored expected value. Two kinds of vector exist. Cipher vectors exercise the transform under a key. Table vectors read back entries of the engine's substitution table. Each kind of check yields an integer result code, and zero means the check passed.

When every vector matches, the sequencer raises a ready flag and drives a fixed signature word, so a host controller can confirm that the device came up correctly configured. A failed comparison or a silent engine ends the run at once. The block then latches into an error state that only a reset clears, and it reports the failing vector index together with a nonzero code.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held, eng_start, st_ready and st_error are 0, st_code is 0, st_fail_idx is 0 and st_signature is 0.
- R2: After reset the vectors are issued strictly in index order starting at 0, one per eng_start pulse of exactly one cycle. The key, data and mode of vector i are stable while that vector is outstanding. eng_mode=0 selects a cipher vector and eng_mode=1 selects a table vector.
- R3: With W=16, vector i<4 (N_CIPHER) is a cipher vector with key = 0xA5C3 ^ (i*0x1357) and data = 0x0F1E + i*0x0101, both mod 2^16. Its expected answer is rotl3(data ^ key) + key. Vector i>=4 is a table vector for entry j=i-4, with key = 0, data = j and expected answer j*37+11. There are 8 vectors in all.
- R4: If all 8 answers match, st_ready becomes 1 and stays 1. st_signature then reads 0x5E1F7E57 (0 whenever not ready), st_code reads 0 and no further start is issued.
- R5: A mismatching answer to a cipher vector sets st_error, sets st_code=1 and sets st_fail_idx to that vector's index.
- R6: A mismatching answer to a table vector sets st_error, sets st_code=2 and sets st_fail_idx to that vector's index.
- R7: If no done arrives within 6 (TIMEOUT_CYC) cycles after the cycle of the start pulse, the check fails with st_code=3 at that index. A done in the 6th cycle is still accepted and judged.
- R8: The error state is sticky. While it holds, st_code and st_fail_idx stay fixed, eng_start and st_ready stay 0 and st_signature stays 0.
- R9: A reset taken from the error state reruns the full test from index 0. A correct engine then reaches ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_start | output | 1 | One-cycle start pulse to the cipher engine |
| eng_mode | output | 1 | 0 = cipher vector, 1 = substitution-table vector |
| eng_key | output | WORD_W | Key of the current vector |
| eng_din | output | WORD_W | Data or table entry of the current vector |
| eng_done | input | 1 | Engine answer strobe |
| eng_dout | input | WORD_W | Engine answer word |
| st_ready | output | 1 | All checks passed |
| st_error | output | 1 | Latched failure |
| st_code | output | 2 | 0 ok, 1 cipher mismatch, 2 table mismatch, 3 timeout |
| st_fail_idx | output | IDX_W | Index of the failing vector |
| st_signature | output | SIG_W | Signature word while ready, else 0 |

## Verification
The answer strobe and the timeout expiry can land in the same cycle. This happens when the engine answers in the last permitted wait cycle, and the design must then judge the answer instead of declaring a timeout. The bench provokes this by sweeping the model engine's latency from 1 up to the limit and then to one beyond it. The limit is expected to still pass, and one cycle beyond it is expected to yield code 3 at index 0. The bench also sweeps a mismatch and a silent engine over every vector index, with expected codes and indices derived from the vector formulas.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    RC_OK      = 2'd0,
    RC_CIPHER  = 2'd1,
    RC_TABLE   = 2'd2,
    RC_TIMEOUT = 2'd3
  } result_code_e;

endpackage

// File: rtl/selftest_rst_sync.sv
module selftest_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/selftest_vec_rom.sv
module selftest_vec_rom #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned N_CIPHER  = 4,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned ROT_AMT   = 3,
  parameter logic [WORD_W-1:0] KEY_SEED  = 16'hA5C3,
  parameter logic [WORD_W-1:0] KEY_STEP  = 16'h1357,
  parameter logic [WORD_W-1:0] DATA_SEED = 16'h0F1E,
  parameter logic [WORD_W-1:0] DATA_STEP = 16'h0101,
  parameter logic [WORD_W-1:0] TBL_MUL   = 16'd37,
  parameter logic [WORD_W-1:0] TBL_ADD   = 16'd11
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic              table_o,
  output logic [WORD_W-1:0] key_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] expect_o
);
  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x);
    return (x << ROT_AMT) | (x >> (WORD_W - ROT_AMT));
  endfunction

  logic [WORD_W-1:0] idx_w;
  logic [WORD_W-1:0] entry_w;

  assign idx_w   = WORD_W'(idx_i);
  assign entry_w = idx_w - WORD_W'(N_CIPHER);

  always_comb begin
    if (32'(idx_i) < 32'(N_CIPHER)) begin
      table_o  = 1'b0;
      key_o    = KEY_SEED ^ (idx_w * KEY_STEP);
      data_o   = DATA_SEED + (idx_w * DATA_STEP);
      expect_o = rotl(data_o ^ key_o) + key_o;
    end else begin
      table_o  = 1'b1;
      key_o    = '0;
      data_o   = entry_w;
      expect_o = (entry_w * TBL_MUL) + TBL_ADD;
    end
  end
endmodule

// File: rtl/selftest_judge.sv
module selftest_judge
  import selftest_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              table_i,
  input  logic [WORD_W-1:0] answer_i,
  input  logic [WORD_W-1:0] expect_i,
  output logic              match_o,
  output result_code_e      miss_code_o
);
  assign match_o     = (answer_i == expect_i);
  assign miss_code_o = table_i ? RC_TABLE : RC_CIPHER;
endmodule

// File: rtl/selftest_wait_timer.sv
module selftest_wait_timer #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign expired_o = run_i && (cnt_q == TW'(LIMIT - 1));
  assign cnt_en    = !run_i || !expired_o;

  always_comb begin
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned N_CIPHER    = 4,
  parameter int unsigned N_TABLE     = 4,
  parameter int unsigned TIMEOUT_CYC = 6,
  parameter int unsigned SIG_W       = 32,
  parameter logic [SIG_W-1:0] SIG_VALUE = 32'h5E1F7E57,
  localparam int unsigned N_VEC = N_CIPHER + N_TABLE,
  localparam int unsigned IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              eng_start,
  output logic              eng_mode,
  output logic [WORD_W-1:0] eng_key,
  output logic [WORD_W-1:0] eng_din,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_dout,
  output logic              st_ready,
  output logic              st_error,
  output logic [1:0]        st_code,
  output logic [IDX_W-1:0]  st_fail_idx,
  output logic [SIG_W-1:0]  st_signature
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_VEC - 1);

  logic              rst_int_n;
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  result_code_e      code_q, code_d;
  logic [IDX_W-1:0]  fidx_q, fidx_d;
  logic              state_en, idx_en, err_en;

  logic              vec_table;
  logic [WORD_W-1:0] vec_key, vec_data, vec_expect;
  logic              ans_match;
  result_code_e      miss_code;
  logic              wait_expired;

  selftest_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  selftest_vec_rom #(
    .WORD_W   (WORD_W),
    .N_CIPHER (N_CIPHER),
    .IDX_W    (IDX_W)
  ) u_rom (
    .idx_i    (idx_q),
    .table_o  (vec_table),
    .key_o    (vec_key),
    .data_o   (vec_data),
    .expect_o (vec_expect)
  );

  selftest_judge #(.WORD_W(WORD_W)) u_judge (
    .table_i     (vec_table),
    .answer_i    (eng_dout),
    .expect_i    (vec_expect),
    .match_o     (ans_match),
    .miss_code_o (miss_code)
  );

  selftest_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (state_q == ST_WAIT),
    .expired_o (wait_expired)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    code_d  = code_q;
    fidx_d  = fidx_q;
    unique case (state_q)
      ST_BOOT:  state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (eng_done) begin
          if (!ans_match) begin
            state_d = ST_FAIL;
            code_d  = miss_code;
            fidx_d  = idx_q;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_PASS;
          end else begin
            state_d = ST_ISSUE;
            idx_d   = idx_q + 1'b1;
          end
        end else if (wait_expired) begin
          state_d = ST_FAIL;
          code_d  = RC_TIMEOUT;
          fidx_d  = idx_q;
        end
      end
      ST_PASS:  state_d = ST_PASS;
      ST_FAIL:  state_d = ST_FAIL;
      default:  state_d = ST_FAIL;
    endcase
  end

  assign state_en = (state_d != state_q);
  assign idx_en   = (idx_d != idx_q);
  assign err_en   = (state_q == ST_WAIT) && (state_d == ST_FAIL);

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_BOOT;
      idx_q   <= '0;
      code_q  <= RC_OK;
      fidx_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (idx_en)   idx_q   <= idx_d;
      if (err_en) begin
        code_q <= code_d;
        fidx_q <= fidx_d;
      end
    end
  end

  assign eng_start    = (state_q == ST_ISSUE);
  assign eng_mode     = vec_table;
  assign eng_key      = vec_key;
  assign eng_din      = vec_data;
  assign st_ready     = (state_q == ST_PASS);
  assign st_error     = (state_q == ST_FAIL);
  assign st_code      = code_q;
  assign st_fail_idx  = fidx_q;
  assign st_signature = st_ready ? SIG_VALUE : '0;
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int unsigned SIG_W = 32,
  parameter logic [SIG_W-1:0] SIG_VALUE = 32'h5E1F7E57
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_start,
  input logic             st_ready,
  input logic             st_error,
  input logic [1:0]       st_code,
  input logic [SIG_W-1:0] st_signature
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_pass_sig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> (st_signature == SIG_VALUE) && (st_code == 2'd0));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |=> st_ready);

  p_err_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_error |-> (st_code != 2'd0));

  p_clean_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_error |-> (st_code == 2'd0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_error |=> st_error && $stable(st_code));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_error |-> !eng_start && !st_ready && (st_signature == '0));
endmodule

bind selftest_seq selftest_seq_chk #(
  .SIG_W     (SIG_W),
  .SIG_VALUE (SIG_VALUE)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_start    (eng_start),
  .st_ready     (st_ready),
  .st_error     (st_error),
  .st_code      (st_code),
  .st_signature (st_signature)
);

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 6;
  localparam int NVEC       = 8;
  localparam int NCIPH      = 4;
  localparam logic [31:0] SIG = 32'h5E1F7E57;

  logic        clk;
  logic        rst_n;
  logic        eng_start, eng_mode, eng_done;
  logic [15:0] eng_key, eng_din, eng_dout;
  logic        st_ready, st_error;
  logic [1:0]  st_code;
  logic [2:0]  st_fail_idx;
  logic [31:0] st_signature;

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;

  // engine model controls
  int lat        = 1;
  int fault_n    = -1;
  int fault_kind = 0;   // 0 corrupt answer, 1 never answer
  int nstart;
  logic busy, corrupt;
  int cnt;
  int mon_k;

  selftest_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .eng_start(eng_start), .eng_mode(eng_mode), .eng_key(eng_key), .eng_din(eng_din),
    .eng_done(eng_done), .eng_dout(eng_dout),
    .st_ready(st_ready), .st_error(st_error), .st_code(st_code),
    .st_fail_idx(st_fail_idx), .st_signature(st_signature)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] v_key(int k);
    if (k < NCIPH) return 16'hA5C3 ^ 16'(k * 16'h1357);
    return 16'h0000;
  endfunction
  function automatic logic [15:0] v_data(int k);
    if (k < NCIPH) return 16'(16'h0F1E + k * 16'h0101);
    return 16'(k - NCIPH);
  endfunction
  function automatic logic [15:0] model(logic [15:0] key, logic [15:0] d, logic m);
    logic [15:0] x;
    if (m) return 16'(d * 16'd37 + 16'd11);
    x = d ^ key;
    return 16'({x[12:0], x[15:13]} + key);
  endfunction

  // cipher engine model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; corrupt <= 1'b0; nstart <= 0;
    end else if (eng_start) begin
      busy    <= !(nstart == fault_n && fault_kind == 1);
      cnt     <= lat - 1;
      corrupt <= (nstart == fault_n && fault_kind == 0);
      nstart  <= nstart + 1;
    end else if (busy) begin
      if (cnt == 0) busy <= 1'b0;
      else          cnt  <= cnt - 1;
    end
  end
  assign eng_done = busy && (cnt == 0);
  assign eng_dout = model(eng_key, eng_din, eng_mode) ^ {15'd0, corrupt};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // order and stimulus monitor
  always @(negedge clk) begin
    if (!rst_n) mon_k = 0;
    else if (eng_start) begin
      chk(mon_k < NVEC && !st_error, "R8 start only during test", mon_k, NVEC);
      chk(eng_key == v_key(mon_k), "R3 key of vector", eng_key, v_key(mon_k));
      chk(eng_din == v_data(mon_k), "R3 data of vector", eng_din, v_data(mon_k));
      chk(eng_mode == (mon_k >= NCIPH), "R2 mode of vector", eng_mode, mon_k >= NCIPH);
      mon_k++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!eng_start && !st_ready && !st_error, "R1 reset flags", {eng_start, st_ready, st_error}, 0);
    chk(st_code == 0 && st_fail_idx == 0, "R1 reset status", {st_code, st_fail_idx}, 0);
    chk(st_signature == 0, "R1 reset signature", st_signature, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input int l, input int fn, input int fk,
                          input bit exp_ok, input int exp_code, input int exp_idx, input string req);
    int n;
    lat = l; fault_n = fn; fault_kind = fk;
    do_reset();
    n = 0;
    while (!st_ready && !st_error && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(st_ready == exp_ok && st_error == !exp_ok, req, {st_ready, st_error}, {exp_ok, !exp_ok});
    chk(st_code == 2'(exp_code), req, st_code, exp_code);
    if (!exp_ok) chk(st_fail_idx == 3'(exp_idx), req, st_fail_idx, exp_idx);
    else begin
      chk(st_signature == SIG, "R4 signature", st_signature, SIG);
      chk(mon_k == NVEC, "R2 all vectors issued", mon_k, NVEC);
    end
    repeat (12) @(negedge clk);
    if (exp_ok) chk(st_ready && st_signature == SIG, "R4 ready held", st_ready, 1);
    else begin
      chk(st_error && !st_ready && st_signature == 0, "R8 sticky error", {st_error, st_ready}, 2);
      chk(st_code == 2'(exp_code) && st_fail_idx == 3'(exp_idx), "R8 status held",
          {st_code, st_fail_idx}, {2'(exp_code), 3'(exp_idx)});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    // latency sweep; latency TMO is the same-cycle answer/expiry case
    for (int l = 1; l <= TMO; l++)
      run_case(l, -1, 0, 1'b1, 0, 0, (l == TMO) ? "R7 answer in last cycle" : "R4 pass");
    run_case(TMO + 1, -1, 0, 1'b0, 3, 0, "R7 late answer times out");
    for (int f = 0; f < NVEC; f++) begin
      run_case(2, f, 0, 1'b0, (f < NCIPH) ? 1 : 2, f, (f < NCIPH) ? "R5 cipher mismatch" : "R6 table mismatch");
      run_case(3, f, 1, 1'b0, 3, f, "R7 silent engine");
    end
    run_case(1, 5, 0, 1'b0, 2, 5, "R6 table mismatch");
    run_case(2, -1, 0, 1'b1, 0, 0, "R9 rerun after error");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule